// File: doc/BRIEF.md
# Transmit Holding Register and Ready/Interrupt Handshake

This block is the transmit half of a byte-wide serial port running with its queues switched off. It has a single one-byte holding register and a shift register behind it. The host writes a byte with a write strobe. The byte waits in the holding register until the shifter is free. It then moves into the shifter, which sends it on the line as one start bit, eight data bits with the least significant bit first, and one stop bit. Each bit lasts a fixed number of clocks.

Two signals tell the host it may write again. The first is an active-low ready output that follows the holding register, not the line. The second is a holding-register-empty interrupt, which is gated by an enable input. The interrupt has two ways to clear: a read of the interrupt status register, signalled on its own input, or a new write into the holding register.

Top module: `txhold_top`

## Requirements
- R1: During and after reset `txRdyN` is 0, `txLine` is 1 (idle high) and `txIrq` is 0.
- R2: A write happens in every clock cycle in which `wrStrobe` is at its active level. The level is low when `WR_ACTIVE_LOW` is 1 and high when it is 0. The write loads `wrData` into the holding register, and `txRdyN` is 1 in the following cycle.
- R3: When the shifter is idle, a loaded byte moves into the shifter at the next clock edge. In that same cycle `txRdyN` returns to 0 and `txLine` goes to 0 (the start bit).
- R4: Each frame on `txLine` is one start bit (0), the eight data bits with bit 0 first, and one stop bit (1). Each bit lasts `CLKS_PER_BIT` cycles, and the line is 1 between frames.
- R5: A byte written while the shifter is busy stays in the holding register with `txRdyN` at 1. It moves into the shifter at the clock edge that ends the last stop-bit cycle, so its start bit follows the previous stop bit with no idle cycle.
- R6: When `irqEnable` is 1, the cycle in which a byte leaves the holding register for the shifter also raises `txIrq`. `txIrq` is never 1 while `irqEnable` is 0.
- R7: A cycle with `isrRead` at 1 clears the pending interrupt, so `txIrq` is 0 in the next cycle. The exception is a cycle in which the holding register empties at the same time; that new event wins.
- R8: A write into the holding register clears the pending interrupt, so `txIrq` is 0 in the next cycle.
- R9: No interrupt is pending until `irqEnable` is set. A rise of `irqEnable` while the holding register is empty makes `txIrq` 1 in the next cycle. A byte that leaves the holding register while `irqEnable` is 0 raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | Host write strobe, polarity set by `WR_ACTIVE_LOW` |
| wrData | input | 8 | Byte to load into the holding register |
| isrRead | input | 1 | High for one cycle when the host reads the interrupt status register |
| irqEnable | input | 1 | Enable for the holding-register-empty interrupt |
| txLine | output | 1 | Serial output, idle high |
| txRdyN | output | 1 | Active-low ready: 0 while the holding register is empty |
| txIrq | output | 1 | Holding-register-empty interrupt, active high |

## Verification
The assertions assume that the host writes only while `txRdyN` is 0. A write into a full holding register replaces the waiting byte, and the frame checks do not describe that case. The assertions also assume that `isrRead` and the write strobe are synchronous single-cycle pulses. The bench's writer task waits for `txRdyN` to be 0 before every write, except in the one test that writes into a busy shifter with an empty holding register on purpose. It changes every input half a cycle away from the sampling edge.

// File: rtl/txhold_pkg.sv
package txhold_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;

  typedef struct packed {
    logic loadHold;     // capture host byte into holding register
    logic moveToShift;  // hand holding register to the shifter
  } txStrobes_t;
endpackage

// File: rtl/txhold_datapath.sv
module txhold_datapath
  import txhold_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              shiftBusy,
  output logic              shiftDone,
  output logic              txLine
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W:0]   shiftReg;   // data bits then stop bit, sent LSB first
  logic [CNT_W-1:0]  clkCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              busyReg;
  logic              lineReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdData <= '0;
    else if (strobes.loadHold) holdData <= wrData;
  end

  assign shiftDone = busyReg && (clkCnt == CNT_LAST) && (bitIdx == IDX_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      clkCnt   <= '0;
      bitIdx   <= '0;
      busyReg  <= 1'b0;
      lineReg  <= 1'b1;
    end else if (strobes.moveToShift) begin
      shiftReg <= {1'b1, holdData};
      clkCnt   <= '0;
      bitIdx   <= '0;
      busyReg  <= 1'b1;
      lineReg  <= 1'b0;
    end else if (busyReg) begin
      if (clkCnt == CNT_LAST) begin
        clkCnt <= '0;
        if (bitIdx == IDX_LAST) begin
          busyReg <= 1'b0;
          lineReg <= 1'b1;
        end else begin
          bitIdx   <= bitIdx + 1'b1;
          lineReg  <= shiftReg[0];
          shiftReg <= {1'b1, shiftReg[DATA_W:1]};
        end
      end else begin
        clkCnt <= clkCnt + 1'b1;
      end
    end
  end

  assign shiftBusy = busyReg;
  assign txLine    = lineReg;
endmodule

// File: rtl/txhold_ctrl.sv
module txhold_ctrl
  import txhold_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrActive,
  input  logic       isrRead,
  input  logic       irqEnable,
  input  logic       shiftBusy,
  input  logic       shiftDone,
  output txStrobes_t strobes,
  output logic       txRdyN,
  output logic       txIrq
);
  logic holdFull;
  logic irqPend;
  logic enPrev;
  logic emptyEvent;

  always_comb begin
    strobes.loadHold    = wrActive;
    strobes.moveToShift = holdFull && (!shiftBusy || shiftDone);
  end

  // holding register emptied while enabled, or enable raised while empty
  assign emptyEvent = irqEnable &&
                      (strobes.moveToShift || (!enPrev && !holdFull));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      irqPend  <= 1'b0;
      enPrev   <= 1'b0;
    end else begin
      enPrev <= irqEnable;
      if (wrActive)                 holdFull <= 1'b1;
      else if (strobes.moveToShift) holdFull <= 1'b0;

      if (wrActive)        irqPend <= 1'b0;
      else if (emptyEvent) irqPend <= 1'b1;
      else if (isrRead)    irqPend <= 1'b0;
    end
  end

  assign txRdyN = holdFull;
  assign txIrq  = irqPend && irqEnable;
endmodule

// File: rtl/txhold_top.sv
module txhold_top
  import txhold_pkg::*;
#(
  parameter int CLKS_PER_BIT  = 16,
  parameter bit WR_ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              isrRead,
  input  logic              irqEnable,
  output logic              txLine,
  output logic              txRdyN,
  output logic              txIrq
);
  txStrobes_t strobes;
  logic wrActive;
  logic shiftBusy;
  logic shiftDone;

  generate
    if (WR_ACTIVE_LOW) begin : g_wrLow
      assign wrActive = !wrStrobe;
    end else begin : g_wrHigh
      assign wrActive = wrStrobe;
    end
  endgenerate

  txhold_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrActive(wrActive), .isrRead(isrRead),
    .irqEnable(irqEnable), .shiftBusy(shiftBusy), .shiftDone(shiftDone),
    .strobes(strobes), .txRdyN(txRdyN), .txIrq(txIrq)
  );

  txhold_datapath #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .shiftBusy(shiftBusy), .shiftDone(shiftDone), .txLine(txLine)
  );
endmodule

// File: rtl/txhold_checker.sv
module txhold_checker #(
  parameter bit WR_ACTIVE_LOW = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic wrStrobe,
  input logic isrRead,
  input logic irqEnable,
  input logic txLine,
  input logic txRdyN,
  input logic txIrq
);
  logic wrOn;
  assign wrOn = WR_ACTIVE_LOW ? !wrStrobe : wrStrobe;

  assert_load_blocks_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrOn |=> txRdyN);

  assert_release_starts_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txRdyN) |-> !txLine);

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> irqEnable);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isrRead && !txRdyN && $stable(irqEnable) && !wrOn) |=> !txIrq);

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrOn |=> !txIrq);
endmodule

bind txhold_top txhold_checker #(.WR_ACTIVE_LOW(WR_ACTIVE_LOW)) u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .isrRead(isrRead),
  .irqEnable(irqEnable), .txLine(txLine), .txRdyN(txRdyN), .txIrq(txIrq)
);

// File: tb/txhold_top_tb.sv
module txhold_top_tb;
  localparam int CPB = 4;

  logic clk = 1'b0;
  logic rstN;
  logic wrStrobe;
  logic [7:0] wrData;
  logic isrRead;
  logic irqEnable;
  logic txLine, txRdyN, txIrq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  txhold_top #(.CLKS_PER_BIT(CPB), .WR_ACTIVE_LOW(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .isrRead(isrRead), .irqEnable(irqEnable),
    .txLine(txLine), .txRdyN(txRdyN), .txIrq(txIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // driver: one active-low strobe cycle, expected byte goes to scoreboard
  task automatic doWrite(logic [7:0] b);
    wrStrobe = 1'b0;
    wrData   = b;
    expQ.push_back(b);
    tick();
    wrStrobe = 1'b1;
  endtask

  task automatic writeWhenReady(logic [7:0] b);
    while (txRdyN) tick();
    doWrite(b);
  endtask

  // monitor: decode frames at bit centres, compare with scoreboard (R4)
  initial begin
    logic [7:0] got;
    forever begin
      tick();
      if (rstN && !txLine) begin
        repeat (CPB / 2 - 1) tick();
        check("R4 start bit", 32'(txLine), 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) tick();
          got[i] = txLine;
        end
        repeat (CPB) tick();
        check("R4 stop bit", 32'(txLine), 32'd1);
        if (expQ.size() == 0) begin
          check("R4 unexpected frame", 32'(got), 32'hFFFF);
        end else begin
          check("R4 frame data", 32'(got), 32'(expQ.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrStrobe = 1'b1; wrData = '0; isrRead = 1'b0; irqEnable = 1'b0;
    repeat (3) tick();
    check("R1 rdy in reset", 32'(txRdyN), 32'd0);
    check("R1 line in reset", 32'(txLine), 32'd1);
    check("R1 irq in reset", 32'(txIrq), 32'd0);
    rstN = 1'b1;
    tick();
    check("R1 rdy after reset", 32'(txRdyN), 32'd0);
    check("R1 irq after reset", 32'(txIrq), 32'd0);

    // R9: enable rise with empty holding register
    irqEnable = 1'b1;
    tick();
    check("R9 enable raises irq", 32'(txIrq), 32'd1);
    // R7: status read clears
    isrRead = 1'b1; tick(); isrRead = 1'b0;
    check("R7 read clears irq", 32'(txIrq), 32'd0);

    // R2, R3, R6: single byte with idle shifter
    doWrite(8'hA5);
    check("R2 rdy high after write", 32'(txRdyN), 32'd1);
    tick();
    check("R3 rdy low at transfer", 32'(txRdyN), 32'd0);
    check("R3 start bit at transfer", 32'(txLine), 32'd0);
    check("R6 irq on transfer", 32'(txIrq), 32'd1);

    // R5, R8: write while shifter busy
    doWrite(8'h3C);
    check("R5 rdy high while waiting", 32'(txRdyN), 32'd1);
    check("R8 write clears irq", 32'(txIrq), 32'd0);
    repeat (10 * CPB - 2) tick();
    check("R5 still in stop bit", 32'(txLine), 32'd1);
    check("R5 still waiting", 32'(txRdyN), 32'd1);
    tick();
    check("R5 back-to-back start", 32'(txLine), 32'd0);
    check("R5 rdy low at handoff", 32'(txRdyN), 32'd0);
    check("R6 irq on handoff", 32'(txIrq), 32'd1);
    isrRead = 1'b1; tick(); isrRead = 1'b0;
    check("R7 read clears irq during frame", 32'(txIrq), 32'd0);
    repeat (10 * CPB + 4) tick();

    // R9: disabled enable raises nothing
    irqEnable = 1'b0;
    tick();
    doWrite(8'h81);
    tick();
    check("R9 no irq while disabled", 32'(txIrq), 32'd0);
    repeat (10 * CPB + 4) tick();
    irqEnable = 1'b1;
    tick();
    check("R9 enable after frame raises irq", 32'(txIrq), 32'd1);

    // more patterns through the scoreboard
    writeWhenReady(8'hFF);
    writeWhenReady(8'h00);
    writeWhenReady(8'h6E);
    writeWhenReady(8'h01);
    while (expQ.size() != 0) tick();
    repeat (2 * CPB) tick();
    check("R4 line idle after frames", 32'(txLine), 32'd1);
    check("R4 scoreboard drained", 32'(expQ.size()), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule